// File: doc/BRIEF.md
# NAND Flash Phase Sequencer

This block drives a raw 8-bit NAND flash bus one phase at a time from a small register file. Software loads a command byte, an address byte count and address word, a data byte count and write data. It then starts each bus phase and polls a sticky done flag for that phase before starting the next one. The controller never chains phases by itself, so a whole flash operation is a short sequence of register writes and status polls.

The block generates the command latch enable, the address latch enable, the active-low write and read strobes and a one-hot set of chip enables. Bytes returned during a read phase are assembled into 32-bit words and queued in a small read FIFO, and software drains that FIFO through one register. Strobe timing is fixed by parameters: every byte slot holds its strobe low for a set number of cycles, then high for a set number.

Top module: `nand_seq`

Register word addresses (`reg_addr`): 0 bank select, 1 phase start and clear controls, 2 command, 3 address count, 4 address word, 5 data count, 6 write data, 7 read FIFO, 8 status.

## Requirements
- R1: A write to the command register (address 2) while the sequencer is idle sends one byte cycle with `nf_cle` high for four clocks and `nf_we_n` low for the first two, with the command byte on `nf_dout`. At the end of the cycle, status bit 2 is set.
- R2: Writing 1 to control bit 0 (address 1) sends (address count + 1) bytes from the address word, least significant byte first. `nf_ale` is high for the whole phase, and status bit 3 is set when the phase ends.
- R3: Control bit 1 starts a read of (data count + 1) bytes on `nf_re_n` pulses. Each byte is sampled in the last low cycle of its pulse. Bytes are packed little-endian into 32-bit words, and a final partial word has its unused upper bytes zero. Status bit 4 is set at the end.
- R4: Control bit 2 starts a write of (data count + 1) bytes. Byte k is lane k mod 4 of the write-data register (lane 0 = bits 7:0). Status bit 4 is set at the end.
- R5: Every strobe stays low for exactly two clocks and then high for two clocks. `nf_cle` and `nf_ale` are never high together and are both low between phases. `nf_we_n` and `nf_re_n` are never low together.
- R6: Status bits 2, 3 and 4 stay set until a status write (address 8) carries a 1 in the same bit. A 0 in that bit leaves the flag unchanged.
- R7: A command write or a phase start issued while a phase is in progress is ignored. No extra bus cycle follows and no done flag is set for it.
- R8: The read FIFO holds four words. Status bit 6 is set when it holds two or more words, and bit 9 is set when it holds four. A word arriving while the FIFO is full is dropped. Reading address 7 pops one word, and reading it while empty returns zero without any pop.
- R9: Control bit 7 empties the read FIFO. Control bit 6 clears the write-data register to zero.
- R10: Bank select bits 2:1 (address 0) drive `nf_ce` for bank 0 and bank 1. A value with more than one of those bits set is ignored, so at most one enable is ever high.
- R11: Status bit 0 follows the `nf_rdy` input.
- R12: After reset, the sequencer is idle. Both strobes are high, `nf_cle`, `nf_ale` and all chip enables are low, every status flag is clear and the read FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 7) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dout | output | 8 | Byte driven to the flash |
| nf_oe | output | 1 | High while the block drives `nf_dout` |
| nf_din | input | 8 | Byte returned by the flash |
| nf_rdy | input | 1 | Flash ready (1) / busy (0) |
| nf_ce | output | NBANK (2) | One-hot chip enables, active high |

## Verification
The bench builds the block with its defaults: two banks, a two-bit address count (up to four address bytes), an eight-bit data count, a four-word FIFO and two-plus-two strobe cycles. The four-word depth lets a twenty-byte read overflow the FIFO, so the full flag, the dropped fifth word and the empty read that follows are all reachable. The two-bit address count lets a three-byte address phase show the byte order. The eight-bit data count covers the single-byte, partial-word, exact-word and multi-word read lengths.

// File: rtl/nand_seq_pkg.sv
// Package: shared phase encoding, register word addresses and bit positions
// for the NAND phase sequencer. Assumes a 4-bit word-addressed register bus.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CMD  = 3'd1,
        PH_ADDR = 3'd2,
        PH_RD   = 3'd3,
        PH_WR   = 3'd4
    } phase_t;

    localparam logic [3:0] RA_SEL  = 4'd0;
    localparam logic [3:0] RA_GO   = 4'd1;
    localparam logic [3:0] RA_CMD  = 4'd2;
    localparam logic [3:0] RA_ACNT = 4'd3;
    localparam logic [3:0] RA_ADDR = 4'd4;
    localparam logic [3:0] RA_DCNT = 4'd5;
    localparam logic [3:0] RA_WDAT = 4'd6;
    localparam logic [3:0] RA_FIFO = 4'd7;
    localparam logic [3:0] RA_STAT = 4'd8;

    // control (address 1) bit positions
    localparam int GB_ADDR = 0;
    localparam int GB_RD   = 1;
    localparam int GB_WR   = 2;
    localparam int GB_CLRW = 6;
    localparam int GB_CLRR = 7;

    // status (address 8) bit positions
    localparam int SB_RDY  = 0;
    localparam int SB_CMD  = 2;
    localparam int SB_ADR  = 3;
    localparam int SB_XFR  = 4;
    localparam int SB_HALF = 6;
    localparam int SB_FULL = 9;

endpackage

// File: rtl/nand_seq_phase.sv
// Phase engine: runs one bus phase (command, address, read or write) of
// lim+1 byte slots, each LO_CYC cycles with the strobe low then HI_CYC high.
// Assumes DCNT_W >= ACNT_W and that start requests are single-cycle pulses;
// starts are only taken while idle.
module nand_seq_phase
    import nand_seq_pkg::*;
#(
    parameter int ACNT_W = 2,
    parameter int DCNT_W = 8,
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go_cmd,
    input  logic                    go_addr,
    input  logic                    go_rd,
    input  logic                    go_wr,
    input  logic [7:0]              cmd_byte,
    input  logic [(8<<ACNT_W)-1:0]  addr_word,
    input  logic [31:0]             wr_word,
    input  logic [ACNT_W-1:0]       acnt,
    input  logic [DCNT_W-1:0]       dcnt,
    output logic                    cle,
    output logic                    ale,
    output logic                    we_n,
    output logic                    re_n,
    output logic                    oe,
    output logic [7:0]              dout,
    output logic                    cap_en,
    output logic [1:0]              cap_lane,
    output logic                    cap_last,
    output logic                    done_cmd,
    output logic                    done_addr,
    output logic                    done_xfer,
    output logic                    busy
);

    localparam int SLOT   = LO_CYC + HI_CYC;
    localparam int SUB_W  = (SLOT > 2) ? $clog2(SLOT) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOT - 1);
    localparam logic [SUB_W-1:0] SUB_CAP  = SUB_W'(LO_CYC - 1);
    localparam logic [SUB_W-1:0] SUB_HI   = SUB_W'(LO_CYC);

    phase_t            phase_q;
    logic [SUB_W-1:0]  sub_q;
    logic [DCNT_W-1:0] bcnt_q;
    logic [DCNT_W-1:0] lim_q;
    logic              last_byte;
    logic              slot_end;
    logic              strobe_lo;

    assign last_byte = (bcnt_q == lim_q);
    assign slot_end  = (phase_q != PH_IDLE) && (sub_q == SUB_LAST);
    assign strobe_lo = (phase_q != PH_IDLE) && (sub_q < SUB_HI);

    // Phase, slot-cycle and byte counters; new phase taken only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sub_q   <= '0;
            bcnt_q  <= '0;
            lim_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            sub_q  <= '0;
            bcnt_q <= '0;
            if (go_cmd) begin
                phase_q <= PH_CMD;
                lim_q   <= '0;
            end else if (go_addr) begin
                phase_q <= PH_ADDR;
                lim_q   <= DCNT_W'(acnt);
            end else if (go_rd) begin
                phase_q <= PH_RD;
                lim_q   <= dcnt;
            end else if (go_wr) begin
                phase_q <= PH_WR;
                lim_q   <= dcnt;
            end
        end else if (slot_end) begin
            sub_q <= '0;
            if (last_byte) phase_q <= PH_IDLE;
            else           bcnt_q  <= bcnt_q + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    // Pin levels and the outgoing byte, decoded from the phase state.
    always_comb begin
        cle  = (phase_q == PH_CMD);
        ale  = (phase_q == PH_ADDR);
        re_n = !(strobe_lo && phase_q == PH_RD);
        we_n = !(strobe_lo && (phase_q == PH_CMD || phase_q == PH_ADDR ||
                               phase_q == PH_WR));
        oe   = (phase_q == PH_CMD) || (phase_q == PH_ADDR) || (phase_q == PH_WR);
        case (phase_q)
            PH_CMD:  dout = cmd_byte;
            PH_ADDR: dout = addr_word[8*int'(bcnt_q[ACNT_W-1:0]) +: 8];
            PH_WR:   dout = wr_word[8*int'(bcnt_q[1:0]) +: 8];
            default: dout = 8'h00;
        endcase
    end

    assign cap_en    = (phase_q == PH_RD) && (sub_q == SUB_CAP);
    assign cap_lane  = bcnt_q[1:0];
    assign cap_last  = last_byte;
    assign done_cmd  = slot_end && last_byte && (phase_q == PH_CMD);
    assign done_addr = slot_end && last_byte && (phase_q == PH_ADDR);
    assign done_xfer = slot_end && last_byte &&
                       (phase_q == PH_RD || phase_q == PH_WR);
    assign busy      = (phase_q != PH_IDLE);

endmodule

// File: rtl/nand_seq_pack.sv
// Read packer: gathers sampled bytes little-endian into a word and emits a
// push when lane 3 fills or the phase's last byte arrives (upper lanes zero).
// Assumes each read phase starts at lane 0.
module nand_seq_pack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [1:0]        cap_lane,
    input  logic              cap_last,
    input  logic [7:0]        din,
    output logic              push,
    output logic [WORD_W-1:0] push_word
);

    logic [WORD_W-1:0] acc_q;

    assign push_word = acc_q | (WORD_W'(din) << (8*int'(cap_lane)));
    assign push      = cap_en && (cap_lane == 2'd3 || cap_last);

    // Accumulator: merge each byte, restart from zero after a push.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (push)   acc_q <= '0;
        else if (cap_en) acc_q <= push_word;
    end

endmodule

// File: rtl/nand_seq_rfifo.sv
// Read FIFO: DEPTH words (power of two), drops pushes while full, ignores
// pops while empty, clear has priority over a push in the same cycle.
module nand_seq_rfifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH):0]     cnt
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok, pop_ok;

    assign push_ok = push && (cnt_q != CNT_W'(DEPTH)) && !clr;
    assign pop_ok  = pop && (cnt_q != '0) && !clr;
    assign head    = mem[rp_q];
    assign cnt     = cnt_q;

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + 1'b1;
            if (pop_ok)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

endmodule

// File: rtl/nand_seq.sv
// NAND phase sequencer top: register file, sticky status, bank enables,
// phase engine, read packer and read FIFO. Software starts each phase and
// polls its done flag. Assumes ACNT_W <= 2 so the address word fits 32 bits.
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int NBANK      = 2,
    parameter int ACNT_W     = 2,
    parameter int DCNT_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int LO_CYC     = 2,
    parameter int HI_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [7:0]        nf_dout,
    output logic              nf_oe,
    input  logic [7:0]        nf_din,
    input  logic              nf_rdy,
    output logic [NBANK-1:0]  nf_ce
);

    localparam int ADDR_W = 8 << ACNT_W;
    localparam int FCNT_W = $clog2(FIFO_DEPTH) + 1;

    logic [NBANK-1:0]  sel_q;
    logic [7:0]        cmd_q;
    logic [ACNT_W-1:0] acnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DCNT_W-1:0] dcnt_q;
    logic [31:0]       wdat_q;
    logic              st_cmd_q, st_adr_q, st_xfr_q;

    logic wr_go, wr_stat, go_cmd, busy;
    logic done_cmd, done_addr, done_xfer;
    logic cap_en, cap_last, push;
    logic [1:0]  cap_lane;
    logic [31:0] push_word, rf_head;
    logic [FCNT_W-1:0] rf_cnt;
    logic [NBANK-1:0]  sel_new;

    assign wr_go   = reg_wr && (reg_addr == RA_GO);
    assign wr_stat = reg_wr && (reg_addr == RA_STAT);
    assign go_cmd  = reg_wr && (reg_addr == RA_CMD) && !busy;
    assign sel_new = reg_wdata[NBANK:1];
    assign nf_ce   = sel_q;

    // Configuration registers; command byte held steady while a phase runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            cmd_q  <= '0;
            acnt_q <= '0;
            addr_q <= '0;
            dcnt_q <= '0;
            wdat_q <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_SEL && $onehot0(sel_new)) sel_q <= sel_new;
            if (go_cmd) cmd_q <= reg_wdata[7:0];
            if (reg_wr && reg_addr == RA_ACNT) acnt_q <= reg_wdata[ACNT_W-1:0];
            if (reg_wr && reg_addr == RA_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_addr == RA_DCNT) dcnt_q <= reg_wdata[DCNT_W-1:0];
            if (reg_wr && reg_addr == RA_WDAT) wdat_q <= reg_wdata;
            else if (wr_go && reg_wdata[GB_CLRW]) wdat_q <= '0;
        end
    end

    // Sticky done flags: set by the engine, cleared by writing 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_cmd_q <= 1'b0;
            st_adr_q <= 1'b0;
            st_xfr_q <= 1'b0;
        end else begin
            if (done_cmd)                          st_cmd_q <= 1'b1;
            else if (wr_stat && reg_wdata[SB_CMD]) st_cmd_q <= 1'b0;
            if (done_addr)                         st_adr_q <= 1'b1;
            else if (wr_stat && reg_wdata[SB_ADR]) st_adr_q <= 1'b0;
            if (done_xfer)                         st_xfr_q <= 1'b1;
            else if (wr_stat && reg_wdata[SB_XFR]) st_xfr_q <= 1'b0;
        end
    end

    nand_seq_phase #(
        .ACNT_W(ACNT_W), .DCNT_W(DCNT_W), .LO_CYC(LO_CYC), .HI_CYC(HI_CYC)
    ) u_phase (
        .clk(clk), .rst_n(rst_n),
        .go_cmd(go_cmd),
        .go_addr(wr_go && reg_wdata[GB_ADDR]),
        .go_rd(wr_go && reg_wdata[GB_RD]),
        .go_wr(wr_go && reg_wdata[GB_WR]),
        .cmd_byte(cmd_q), .addr_word(addr_q), .wr_word(wdat_q),
        .acnt(acnt_q), .dcnt(dcnt_q),
        .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
        .oe(nf_oe), .dout(nf_dout),
        .cap_en(cap_en), .cap_lane(cap_lane), .cap_last(cap_last),
        .done_cmd(done_cmd), .done_addr(done_addr), .done_xfer(done_xfer),
        .busy(busy)
    );

    nand_seq_pack #(.WORD_W(32)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_lane(cap_lane), .cap_last(cap_last),
        .din(nf_din), .push(push), .push_word(push_word)
    );

    nand_seq_rfifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rfifo (
        .clk(clk), .rst_n(rst_n),
        .clr(wr_go && reg_wdata[GB_CLRR]),
        .push(push), .wdata(push_word),
        .pop(reg_rd && reg_addr == RA_FIFO),
        .head(rf_head), .cnt(rf_cnt)
    );

    // Read-back multiplexer, including the assembled status word.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SEL:  reg_rdata = 32'(sel_q) << 1;
            RA_CMD:  reg_rdata = 32'(cmd_q);
            RA_ACNT: reg_rdata = 32'(acnt_q);
            RA_ADDR: reg_rdata = 32'(addr_q);
            RA_DCNT: reg_rdata = 32'(dcnt_q);
            RA_WDAT: reg_rdata = wdat_q;
            RA_FIFO: reg_rdata = (rf_cnt == '0) ? 32'h0 : rf_head;
            RA_STAT: begin
                reg_rdata[SB_RDY]  = nf_rdy;
                reg_rdata[SB_CMD]  = st_cmd_q;
                reg_rdata[SB_ADR]  = st_adr_q;
                reg_rdata[SB_XFR]  = st_xfr_q;
                reg_rdata[SB_HALF] = (rf_cnt >= FCNT_W'(FIFO_DEPTH/2));
                reg_rdata[SB_FULL] = (rf_cnt == FCNT_W'(FIFO_DEPTH));
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nand_seq_chk.sv
// Checker for nand_seq: pin exclusivity, strobe low width, bank enables,
// flag stickiness and FIFO occupancy/empty-read behaviour. Bound below.
module nand_seq_chk
    import nand_seq_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [3:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             nf_cle,
    input logic             nf_ale,
    input logic             nf_we_n,
    input logic             nf_re_n,
    input logic [NBANK-1:0] nf_ce,
    input logic             st_cmd,
    input logic [CNT_W-1:0] rf_cnt
);

    a_r5_latches_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    a_r5_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    a_r5_we_low_two: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_we_n) |=> !nf_we_n);

    a_r5_re_low_two: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_re_n) |=> !nf_re_n);

    a_r1_cle_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_cle) |-> !nf_we_n);

    a_r10_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nf_ce));

    a_r6_cmd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_cmd && !(reg_wr && reg_addr == RA_STAT && reg_wdata[SB_CMD]) |=> st_cmd);

    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_FIFO && rf_cnt == '0) |-> reg_rdata == 32'h0);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rf_cnt <= CNT_W'(DEPTH));

endmodule

bind nand_seq nand_seq_chk #(
    .NBANK(NBANK), .DEPTH(FIFO_DEPTH), .CNT_W(FCNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_ce(nf_ce), .st_cmd(st_cmd_q), .rf_cnt(rf_cnt)
);

// File: tb/nand_seq_bench.sv
module nand_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_oe, nf_rdy = 1'b1;
    logic [7:0]  nf_dout, nf_din;
    logic [1:0]  nf_ce;

    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    nand_seq u_nand_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dout(nf_dout), .nf_oe(nf_oe), .nf_din(nf_din), .nf_rdy(nf_rdy),
        .nf_ce(nf_ce)
    );

    // Flash model: byte value counts up from A0 per read pulse since rd_start.
    int rd_pulses = 0;
    int rd_start = 0;
    always @(posedge nf_re_n) rd_pulses = rd_pulses + 1;
    assign nf_din = 8'hA0 + 8'(rd_pulses - rd_start);

    // Bus log of written bytes, latched on each rising write strobe.
    logic [7:0] lg_byte [64];
    logic       lg_cle [64];
    logic       lg_ale [64];
    int nlog = 0;
    always @(posedge nf_we_n) if (rst_n && nlog < 64) begin
        lg_byte[nlog] = nf_dout;
        lg_cle[nlog]  = nf_cle;
        lg_ale[nlog]  = nf_ale;
        nlog = nlog + 1;
    end

    // Cycle counters of strobe-low and latch-enable levels.
    int we_lo = 0, cle_hi = 0, ale_hi = 0;
    always @(negedge clk) if (rst_n) begin
        if (!nf_we_n) we_lo = we_lo + 1;
        if (nf_cle)   cle_hi = cle_hi + 1;
        if (nf_ale)   ale_hi = ale_hi + 1;
    end

    localparam logic [3:0] A_SEL = 0, A_GO = 1, A_CMD = 2, A_ACNT = 3,
                           A_ADDR = 4, A_DCNT = 5, A_WDAT = 6, A_FIFO = 7,
                           A_STAT = 8;

    // Read vectors: {data count, words expected, word0, word1}
    localparam logic [73:0] RTAB [4] = '{
        {8'd0, 2'd1, 32'h000000A0, 32'h00000000},
        {8'd1, 2'd1, 32'h0000A1A0, 32'h00000000},
        {8'd3, 2'd1, 32'hA3A2A1A0, 32'h00000000},
        {8'd5, 2'd2, 32'hA3A2A1A0, 32'h0000A5A4}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_bit(input int b);
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(A_STAT, s);
            if (s[b]) break;
        end
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_err + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int l0, w0, c0, a0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 pins", {28'd0, nf_cle, nf_ale, nf_we_n, nf_re_n}, 32'h3);
        check("R12 ce", 32'(nf_ce), 32'h0);
        rd(A_STAT, v);
        check("R12 status", v, 32'h1);
        rd(A_FIFO, v);
        check("R12 fifo empty", v, 32'h0);

        // R11 ready mirror
        nf_rdy = 1'b0;
        rd(A_STAT, v);
        check("R11 busy", 32'(v[0]), 32'h0);
        nf_rdy = 1'b1;
        rd(A_STAT, v);
        check("R11 ready", 32'(v[0]), 32'h1);

        // R10 bank enables
        wr(A_SEL, 32'h2);
        check("R10 bank0", 32'(nf_ce), 32'h1);
        wr(A_SEL, 32'h4);
        check("R10 bank1", 32'(nf_ce), 32'h2);
        wr(A_SEL, 32'h6);
        check("R10 two set ignored", 32'(nf_ce), 32'h2);

        // R1 / R5 command cycle
        l0 = nlog; w0 = we_lo; c0 = cle_hi; a0 = ale_hi;
        wr(A_CMD, 32'h90);
        wait_bit(2);
        rd(A_STAT, v);
        check("R1 cmd done", 32'(v[2]), 32'h1);
        check("R1 one byte", 32'(nlog - l0), 32'd1);
        check("R1 byte", {22'd0, lg_cle[l0], lg_ale[l0], lg_byte[l0]}, {22'd0, 2'b10, 8'h90});
        check("R5 we low cycles", 32'(we_lo - w0), 32'd2);
        check("R1 cle cycles", 32'(cle_hi - c0), 32'd4);
        check("R5 no ale", 32'(ale_hi - a0), 32'd0);
        check("R5 idle latches", {30'd0, nf_cle, nf_ale}, 32'h0);

        // R6 sticky, write-one-to-clear
        wr(A_STAT, 32'h0);
        rd(A_STAT, v);
        check("R6 zero keeps", 32'(v[2]), 32'h1);
        wr(A_STAT, 32'h4);
        rd(A_STAT, v);
        check("R6 one clears", 32'(v[2]), 32'h0);

        // R2 address phase
        wr(A_ACNT, 32'd2);
        wr(A_ADDR, 32'h00CCBBAA);
        l0 = nlog; a0 = ale_hi; w0 = we_lo;
        wr(A_GO, 32'h1);
        wait_bit(3);
        rd(A_STAT, v);
        check("R2 addr done", 32'(v[3]), 32'h1);
        check("R2 count", 32'(nlog - l0), 32'd3);
        for (int k = 0; k < 3; k++)
            check("R2 byte", {22'd0, lg_cle[l0+k], lg_ale[l0+k], lg_byte[l0+k]},
                  {22'd0, 2'b01, 8'(8'hAA + 8'h11 * k)});
        check("R2 ale whole phase", 32'(ale_hi - a0), 32'd12);
        check("R5 we low per byte", 32'(we_lo - w0), 32'd6);
        wr(A_STAT, 32'h8);

        // R4 write phase
        wr(A_WDAT, 32'h44332211);
        wr(A_DCNT, 32'd5);
        l0 = nlog;
        wr(A_GO, 32'h4);
        wait_bit(4);
        check("R4 count", 32'(nlog - l0), 32'd6);
        for (int k = 0; k < 6; k++)
            check("R4 byte", {22'd0, lg_cle[l0+k], lg_ale[l0+k], lg_byte[l0+k]},
                  {22'd0, 2'b00, 8'(8'h11 * ((k % 4) + 1))});
        wr(A_STAT, 32'h10);
        // R9 write data clear
        wr(A_GO, 32'h40);
        rd(A_WDAT, v);
        check("R9 wdata cleared", v, 32'h0);

        // R3 read vector table
        for (int t = 0; t < 4; t++) begin
            wr(A_DCNT, 32'(RTAB[t][73:66]));
            rd_start = rd_pulses;
            wr(A_GO, 32'h2);
            wait_bit(4);
            rd(A_STAT, v);
            check("R3 xfer done", 32'(v[4]), 32'h1);
            rd(A_FIFO, v);
            check("R3 word0", v, RTAB[t][63:32]);
            if (RTAB[t][65:64] == 2'd2) begin
                rd(A_FIFO, v);
                check("R3 word1", v, RTAB[t][31:0]);
            end
            rd(A_FIFO, v);
            check("R8 drained reads zero", v, 32'h0);
            wr(A_STAT, 32'h10);
        end

        // R7 starts while busy are ignored
        wr(A_DCNT, 32'd7);
        rd_start = rd_pulses;
        l0 = nlog;
        wr(A_GO, 32'h2);
        wr(A_CMD, 32'h70);
        wr(A_GO, 32'h1);
        wait_bit(4);
        repeat (20) @(negedge clk);
        rd(A_STAT, v);
        check("R7 no write pulses", 32'(nlog - l0), 32'd0);
        check("R7 no cmd/addr done", 32'(v[3:2]), 32'h0);
        check("R8 half full", 32'(v[6]), 32'h1);
        check("R8 not full", 32'(v[9]), 32'h0);
        // R9 read FIFO clear
        wr(A_GO, 32'h80);
        rd(A_STAT, v);
        check("R9 cleared half flag", 32'(v[6]), 32'h0);
        rd(A_FIFO, v);
        check("R9 cleared fifo empty", v, 32'h0);
        wr(A_STAT, 32'h10);

        // R8 overflow: 20 bytes -> 5 words, fifth dropped
        wr(A_DCNT, 32'd19);
        rd_start = rd_pulses;
        wr(A_GO, 32'h2);
        wait_bit(4);
        rd(A_STAT, v);
        check("R8 full flag", 32'(v[9]), 32'h1);
        check("R8 half with full", 32'(v[6]), 32'h1);
        for (int k = 0; k < 4; k++) begin
            rd(A_FIFO, v);
            check("R8 word", v, {8'(8'hA3 + 4*k), 8'(8'hA2 + 4*k),
                                 8'(8'hA1 + 4*k), 8'(8'hA0 + 4*k)});
        end
        rd(A_FIFO, v);
        check("R8 dropped word", v, 32'h0);
        rd(A_STAT, v);
        check("R8 empty flags", {30'd0, v[9], v[6]}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule